// File: doc/BRIEF.md
# Receive Frame ID Range Filter Bank

This block screens incoming frame identifiers for a receive queue against a bank of four programmable identifier windows. Each window has a lower and an upper boundary, and each can be switched on and set to work either as an acceptance window or as a rejection window. The identifier presented on `chk_id` is judged combinationally against the stored settings, and `chk_accept` says whether the frame may enter the queue.

Software never reaches the eight boundary values directly. A single 16-bit configuration register acts as a pointer and a data port. A pointer field names the window and one bit names the boundary (lower or upper). A full-width write stores the value field into the boundary that the written pointer names. A write-mode bit lets software move the pointer without touching any boundary. Boundary values are only stored while the protocol controller reports its configuration state. The pointer may be moved at any time. A second 16-bit control register holds the enable and mode bits for each window.

Top module: `rxid_range_filter`

## Requirements
- R1: After reset, `cfg_rdata`, `ctl_rdata` and every stored boundary are 0, and `chk_accept` is 1.
- R2: A configuration write with `cfg_full`=1 loads bit 14 (boundary select, 0 lower / 1 upper) and bits 13:12 (window number 0..3) in any protocol state. These fields read back at the same positions in `cfg_rdata`. Bits 15 and 11 read as 0.
- R3: A configuration write with `cfg_full`=1, bit 15 = 0 and `cfg_state`=1 stores bits 10:0 into the boundary named by the written bits 14:12. `cfg_rdata[10:0]` always shows the boundary that the current pointer names.
- R4: A configuration write with bit 15 = 1 moves the pointer only. No boundary changes.
- R5: A configuration write with `cfg_state`=0 still moves the pointer, but no boundary changes.
- R6: A configuration write with `cfg_full`=0 changes nothing.
- R7: A control write stores bits 3:0 (enable of windows 3..0) and bits 11:8 (mode of windows 3..0, 0 acceptance / 1 rejection) in any state. `ctl_rdata` returns them, and all other bits read 0.
- R8: An identifier is inside a window when lower <= id <= upper, with both ends included.
- R9: A frame is dropped when any enabled rejection window contains its identifier.
- R10: When at least one acceptance window is enabled, a frame that no rejection window drops is accepted only if an enabled acceptance window contains it.
- R11: With no window enabled, every identifier is accepted. A disabled window never affects the decision, whatever its mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_state | input | 1 | Protocol controller is in its configuration state |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_full | input | 1 | Write access is full 16-bit width |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Pointer fields and the addressed boundary |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Enable and mode bits |
| chk_id | input | 11 | Frame identifier under test |
| chk_accept | output | 1 | 1 = frame passes the filter bank |

## Verification
A boundary rewrite and a control-register write can land on the same clock edge as a frame being judged. The bench drives a configuration write that widens window 0 together with a control write that enables that window, while an identifier outside the old window sits on `chk_id`. The decision is sampled before the edge, where it must follow the old settings (nothing enabled, so accept). It is sampled again after the edge, where it must follow both new settings together, at an identifier just inside and one just outside the widened window.

// File: rtl/rxf_pkg.sv
// Shared constants and types for the frame ID range filter bank.
// Assumes a 16-bit register layout and at most four windows.
package rxf_pkg;
    localparam int ID_W      = 11;
    localparam int NFILT     = 4;
    localparam int SEL_W     = $clog2(NFILT);
    localparam int NBND      = 2 * NFILT;
    localparam int WMODE_BIT = 15;
    localparam int BSEL_BIT  = 14;
    localparam int FSEL_LSB  = 12;
    localparam int MODE_LSB  = 8;

    typedef struct packed {
        logic             bsel;
        logic [SEL_W-1:0] fsel;
    } rxf_ptr_t;
endpackage

// File: rtl/rxf_regs.sv
// Register decode: holds the boundary pointer and the control bits,
// and produces the boundary write request. Assumes the 16-bit layout in rxf_pkg.
module rxf_regs
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_state,
    input  logic             cfg_wr,
    input  logic             cfg_full,
    input  logic [15:0]      cfg_wdata,
    input  logic             ctl_wr,
    input  logic [15:0]      ctl_wdata,
    output rxf_ptr_t         ptr_q,
    output logic             bnd_we,
    output rxf_ptr_t         bnd_wptr,
    output logic [ID_W-1:0]  bnd_wval,
    output logic [NFILT-1:0] en_q,
    output logic [NFILT-1:0] mode_q
);
    logic     cfg_take;
    rxf_ptr_t wptr;
    logic     unused_bits;

    // Decode the written pointer and decide whether a boundary store is allowed.
    always_comb begin
        cfg_take    = cfg_wr && cfg_full;
        wptr.bsel   = cfg_wdata[BSEL_BIT];
        wptr.fsel   = cfg_wdata[FSEL_LSB +: SEL_W];
        bnd_we      = cfg_take && !cfg_wdata[WMODE_BIT] && cfg_state;
        bnd_wptr    = wptr;
        bnd_wval    = cfg_wdata[ID_W-1:0];
        unused_bits = ^{cfg_wdata, ctl_wdata};
    end

    // Pointer register: follows every full-width write in any state.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (cfg_take) ptr_q <= wptr;
    end

    // Control register: enable and mode bits, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
        end else if (ctl_wr) begin
            en_q   <= ctl_wdata[NFILT-1:0];
            mode_q <= ctl_wdata[MODE_LSB +: NFILT];
        end
    end
endmodule

// File: rtl/rxf_bound_store.sv
// Boundary storage: 2*NFILT identifier values, one write port and one
// read port. Entry 2*n holds the lower bound of window n, 2*n+1 the upper.
module rxf_bound_store
    import rxf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  rxf_ptr_t             wptr,
    input  logic [ID_W-1:0]      wval,
    input  rxf_ptr_t             rptr,
    output logic [ID_W-1:0]      rval,
    output logic [NBND*ID_W-1:0] bnd_flat
);
    logic [ID_W-1:0] bnd [NBND];
    logic [SEL_W:0]  widx;
    logic [SEL_W:0]  ridx;

    // Map pointers to entry indices.
    always_comb begin
        widx = {wptr.fsel, wptr.bsel};
        ridx = {rptr.fsel, rptr.bsel};
        rval = bnd[ridx];
    end

    for (genvar e = 0; e < NBND; e++) begin : g_ent
        // One boundary register, written when the write pointer names it.
        always_ff @(posedge clk) begin
            if (!rst_n)                        bnd[e] <= '0;
            else if (we && widx == (SEL_W+1)'(e)) bnd[e] <= wval;
        end
        assign bnd_flat[e*ID_W +: ID_W] = bnd[e];
    end
endmodule

// File: rtl/rxf_match.sv
// Filter evaluation: inclusive window compare per filter and the combined
// accept/drop decision. Purely combinational.
module rxf_match
    import rxf_pkg::*;
(
    input  logic [NBND*ID_W-1:0] bnd_flat,
    input  logic [NFILT-1:0]     en,
    input  logic [NFILT-1:0]     mode,
    input  logic [ID_W-1:0]      id,
    output logic                 accept
);
    logic [NFILT-1:0] hit;

    for (genvar f = 0; f < NFILT; f++) begin : g_win
        logic [ID_W-1:0] lo;
        logic [ID_W-1:0] hi;
        assign lo     = bnd_flat[(2*f)*ID_W   +: ID_W];
        assign hi     = bnd_flat[(2*f+1)*ID_W +: ID_W];
        assign hit[f] = (id >= lo) && (id <= hi);
    end

    // Combine: any rejection hit drops; enabled acceptance windows must hit.
    always_comb begin
        logic rej_hit;
        logic acc_on;
        logic acc_hit;
        rej_hit = |(en & mode & hit);
        acc_on  = |(en & ~mode);
        acc_hit = |(en & ~mode & hit);
        accept  = !rej_hit && (!acc_on || acc_hit);
    end
endmodule

// File: rtl/rxid_range_filter.sv
// Top: frame ID range filter bank with an indirect boundary register and
// a control register. Assumes a single register writer and NFILT <= 4.
module rxid_range_filter
    import rxf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_state,
    input  logic            cfg_wr,
    input  logic            cfg_full,
    input  logic [15:0]     cfg_wdata,
    output logic [15:0]     cfg_rdata,
    input  logic            ctl_wr,
    input  logic [15:0]     ctl_wdata,
    output logic [15:0]     ctl_rdata,
    input  logic [ID_W-1:0] chk_id,
    output logic            chk_accept
);
    rxf_ptr_t             ptr_q;
    rxf_ptr_t             bnd_wptr;
    logic                 bnd_we;
    logic [ID_W-1:0]      bnd_wval;
    logic [ID_W-1:0]      bnd_rval;
    logic [NFILT-1:0]     en_q;
    logic [NFILT-1:0]     mode_q;
    logic [NBND*ID_W-1:0] bnd_flat;

    rxf_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_state(cfg_state),
        .cfg_wr(cfg_wr), .cfg_full(cfg_full), .cfg_wdata(cfg_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ptr_q(ptr_q), .bnd_we(bnd_we), .bnd_wptr(bnd_wptr),
        .bnd_wval(bnd_wval), .en_q(en_q), .mode_q(mode_q)
    );

    rxf_bound_store u_store (
        .clk(clk), .rst_n(rst_n), .we(bnd_we), .wptr(bnd_wptr),
        .wval(bnd_wval), .rptr(ptr_q), .rval(bnd_rval), .bnd_flat(bnd_flat)
    );

    rxf_match u_match (
        .bnd_flat(bnd_flat), .en(en_q), .mode(mode_q),
        .id(chk_id), .accept(chk_accept)
    );

    // Assemble read views of both registers.
    always_comb begin
        cfg_rdata                          = '0;
        cfg_rdata[BSEL_BIT]                = ptr_q.bsel;
        cfg_rdata[FSEL_LSB +: SEL_W]       = ptr_q.fsel;
        cfg_rdata[ID_W-1:0]                = bnd_rval;
        ctl_rdata                          = '0;
        ctl_rdata[NFILT-1:0]               = en_q;
        ctl_rdata[MODE_LSB +: NFILT]       = mode_q;
    end
endmodule

// File: rtl/rxid_range_filter_chk.sv
// Checker for rxid_range_filter: register write rules and decision sanity.
module rxid_range_filter_chk
    import rxf_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_state,
    input logic                 cfg_wr,
    input logic                 cfg_full,
    input logic [15:0]          cfg_wdata,
    input logic [15:0]          cfg_rdata,
    input logic                 ctl_wr,
    input logic [15:0]          ctl_wdata,
    input logic [15:0]          ctl_rdata,
    input logic                 chk_accept,
    input logic [NBND*ID_W-1:0] bnd_flat
);
    localparam logic [15:0] CTL_MASK = 16'(((1 << NFILT) - 1) | (((1 << NFILT) - 1) << MODE_LSB));

    AST_PTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_full |=> cfg_rdata[14:12] == $past(cfg_wdata[14:12])); // R2
    AST_BOUND_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_full && !cfg_wdata[15] && cfg_state |=> cfg_rdata[10:0] == $past(cfg_wdata[10:0])); // R3
    AST_WMODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_wdata[15] |=> $stable(bnd_flat)); // R4
    AST_LOCKED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !cfg_state |=> $stable(bnd_flat)); // R5
    AST_NARROW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !cfg_full |=> $stable(cfg_rdata)); // R6
    AST_CTL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ctl_rdata == ($past(ctl_wdata) & CTL_MASK)); // R7
    AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[NFILT-1:0] == '0 |-> chk_accept); // R11
endmodule

bind rxid_range_filter rxid_range_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_state(cfg_state), .cfg_wr(cfg_wr),
    .cfg_full(cfg_full), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .chk_accept(chk_accept), .bnd_flat(bnd_flat)
);

// File: tb/rxid_range_filter_tb.sv
module rxid_range_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_state = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_full = 1'b1;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic [10:0] chk_id = '0;
    logic        chk_accept;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rxid_range_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_state(cfg_state), .cfg_wr(cfg_wr),
        .cfg_full(cfg_full), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .chk_id(chk_id), .chk_accept(chk_accept)
    );

    // Windows after programming: 0:[10,20] 1:[15,30] 2:[100,200] 3:[0x7F0,0x7FF]
    // Vector fields: {control word, identifier, expected accept}
    localparam int NV = 15;
    localparam logic [27:0] VEC [NV] = '{
        {16'h0000, 11'd5,     1'b1},  // R11 none enabled
        {16'h0001, 11'd10,    1'b1},  // R8 lower edge
        {16'h0001, 11'd20,    1'b1},  // R8 upper edge
        {16'h0001, 11'd21,    1'b0},  // R10 above
        {16'h0001, 11'd9,     1'b0},  // R10 below
        {16'h0101, 11'd15,    1'b0},  // R9 reject hit
        {16'h0101, 11'd25,    1'b1},  // R9 reject miss
        {16'h0203, 11'd12,    1'b1},  // R10 acc hit, rej miss
        {16'h0203, 11'd16,    1'b0},  // R9 rej wins
        {16'h0005, 11'd150,   1'b1},  // R10 second window hits
        {16'h0005, 11'd50,    1'b0},  // R10 no window hits
        {16'h0800, 11'h7F5,   1'b1},  // R11 mode set, not enabled
        {16'h0808, 11'h7FF,   1'b0},  // R9 top edge rejected
        {16'h080C, 11'h7F0,   1'b0},  // R9 over acceptance miss
        {16'h080C, 11'd120,   1'b1}   // R10 acc hit, rej miss
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [15:0] d, input logic full);
        @(negedge clk);
        cfg_wdata = d; cfg_full = full; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_full = 1'b1;
    endtask

    task automatic wr_ctl(input logic [15:0] d);
        @(negedge clk);
        ctl_wdata = d; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    function automatic logic [15:0] cw(input logic up, input logic [1:0] f, input logic [10:0] v);
        return {1'b0, up, f, 1'b0, v};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cfg_rdata", 32'(cfg_rdata), 32'h0);
        check("R1 ctl_rdata", 32'(ctl_rdata), 32'h0);
        chk_id = 11'h7FF;
        #1 check("R1 accept", 32'(chk_accept), 32'h1);

        wr_cfg(cw(0, 0, 11'd10), 1);   wr_cfg(cw(1, 0, 11'd20), 1);
        wr_cfg(cw(0, 1, 11'd15), 1);   wr_cfg(cw(1, 1, 11'd30), 1);
        wr_cfg(cw(0, 2, 11'd100), 1);  wr_cfg(cw(1, 2, 11'd200), 1);
        wr_cfg(cw(0, 3, 11'h7F0), 1);  wr_cfg(cw(1, 3, 11'h7FF), 1);
        check("R3 last store", 32'(cfg_rdata), 32'(cw(1, 3, 11'h7FF)));

        for (int i = 0; i < NV; i++) begin
            wr_ctl(VEC[i][27:12]);
            chk_id = VEC[i][11:1];
            #1 check($sformatf("R8-table vector %0d", i), 32'(chk_accept), 32'(VEC[i][0]));
        end

        // R4: write mode set moves pointer, keeps boundary
        wr_cfg({1'b1, 1'b1, 2'd1, 1'b0, 11'h555}, 1);
        check("R4 pointer moved, bound kept", 32'(cfg_rdata), 32'(cw(1, 1, 11'd30)));
        // R2: pointer moves without data store to another entry
        wr_cfg({1'b1, 1'b0, 2'd2, 1'b0, 11'h000}, 1);
        check("R2 pointer readback", 32'(cfg_rdata), 32'(cw(0, 2, 11'd100)));
        // R5: locked state, store suppressed, pointer still follows
        cfg_state = 1'b0;
        wr_cfg(cw(1, 0, 11'h3AA), 1);
        check("R5 locked store", 32'(cfg_rdata), 32'(cw(1, 0, 11'd20)));
        // R6: narrow write ignored
        wr_cfg(cw(0, 3, 11'h001), 0);
        check("R6 narrow ignored", 32'(cfg_rdata), 32'(cw(1, 0, 11'd20)));
        cfg_state = 1'b1;
        wr_cfg(cw(0, 3, 11'h002), 0);
        check("R6 narrow ignored in config", 32'(cfg_rdata), 32'(cw(1, 0, 11'd20)));
        // R7: control bits, unused positions read zero
        wr_ctl(16'hFFFF);
        check("R7 ctl mask", 32'(ctl_rdata), 32'h0F0F);
        wr_ctl(16'h0000);
        check("R7 ctl clear", 32'(ctl_rdata), 32'h0000);

        // Same-edge boundary write and control write while an ID is judged
        chk_id = 11'd25;
        @(negedge clk);
        cfg_wdata = cw(1, 0, 11'd30); cfg_full = 1'b1; cfg_wr = 1'b1;
        ctl_wdata = 16'h0001; ctl_wr = 1'b1;
        #1 check("R11 before edge", 32'(chk_accept), 32'h1);
        @(negedge clk);
        cfg_wr = 1'b0; ctl_wr = 1'b0;
        #1 check("R8 widened window", 32'(chk_accept), 32'h1);
        chk_id = 11'd31;
        #1 check("R10 beyond widened window", 32'(chk_accept), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule